// File: doc/BRIEF.md
# Program-Flow Trace Encoder

This block sits beside the execution stage of a processor core. Each cycle it takes at most one retired instruction and turns it into a small trace that an offline decoder can follow, given a copy of the program image. Only two things are sent. The first is an event code for each cycle. The second is the set of addresses the decoder cannot work out by itself: the instruction address at which tracing (re)starts, and the target of every register-based branch. Sequential execution and direct branches cost no address bytes, because the decoder reads their successors from the image.

The output is an 8-bit port that carries two beats per clock cycle. The status beat is meant for the rising edge and the address beat for the falling edge. This block presents both beats in parallel, each one as a registered value, and the double-data-rate output cells that launch them are left to the pad ring. Address bytes queue in a small byte FIFO and leave one per cycle, most significant byte first.

The retire stream is real time and cannot be stalled, so it has a valid strobe and no ready. The trace sink is a free-running port and cannot push back, so the address beat carries a valid qualifier and no ready. Back-pressure is handled inside the block. When the FIFO cannot take a branch target, the block reports a loss and later sends a fresh full address so the decoder can resynchronise.

Top module: `trace_flow_encoder`

## Requirements
- R1: A synchronous active-high `rst` gives `status_beat`=0x00 and `addr_valid`=0 from the next cycle on. It also discards every queued byte, so no byte queued before reset is ever presented. After reset the block waits to send a fresh start address.
- R2: While a start address is owed, the first enabled retire that finds room sends that instruction's own 32-bit `retire_addr` on the address stream as four bytes, most significant byte first. The status beat for that retire is the normal code for its kind.
- R3: A retire with `retire_kind` 0 (sequential) or 3 (reserved, handled as sequential) gives status 0x01 and queues no address byte.
- R4: A retire with `retire_kind` 1 (direct branch) gives status 0x02 and queues no address byte.
- R5: A retire with `retire_kind` 2 (indirect branch) gives status 0x03 and queues the four bytes of `retire_target`, most significant byte first.
- R6: A cycle with no retire gives status 0x00, and so does a cycle with `trace_en` low. While `trace_en` is low nothing is queued. Lowering `trace_en` means a start address is owed again.
- R7: The status for a retire sampled at clock edge n is shown after edge n. With an empty FIFO, the first queued byte shows on `addr_beat`, with `addr_valid`=1, after edge n+1. Each following byte shows one cycle later, in queue order.
- R8: Free FIFO space is judged from the occupancy at the start of the cycle. An indirect branch that finds fewer than 4 free bytes gives status 0x04 and queues nothing, and a start address is then owed. While a start address is owed, a retire that finds too little room also gives 0x04.
- R9: When a start address is owed and the retire is an indirect branch, the block needs 8 free bytes. It then queues the instruction address followed by the target, and gives status 0x03.
- R10: Queue occupancy never exceeds `DEPTH`. Bytes are neither dropped nor reordered after they are queued, and `addr_valid` is low whenever there is no byte to show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Tracing enable; low suppresses events and forces a resync |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_addr | input | 32 | Address of the retiring instruction |
| retire_kind | input | 2 | 0 sequential, 1 direct branch, 2 indirect branch, 3 reserved (sequential) |
| retire_target | input | 32 | Target of an indirect branch |
| status_beat | output | 8 | Rising-edge beat: per-cycle event code |
| addr_beat | output | 8 | Falling-edge beat: next queued address byte |
| addr_valid | output | 1 | `addr_beat` holds a real byte |

## Verification
The bench aims at the resynchronisation paths. It fills the FIFO with back-to-back indirect branches until one no longer fits, then checks that this branch reports 0x04 without leaving a partial target in the queue, and that the next retire sends its own address. A design that counted the byte being popped in the same cycle as free space would accept that branch. It also owes a start address when an indirect branch arrives, where a design that reserved only four bytes would lose the target or misorder the two addresses. Reset and disable in the middle of a stream are checked for stale bytes and for a missing fresh start address. The first address byte is sampled in its exact cycle, to catch an extra or a missing register stage.

// File: rtl/trace_pkg.sv
`timescale 1ns/1ps
package trace_pkg;
  localparam int ADDR_W    = 32;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int PUSH_MAX  = 2 * ADDR_BYTES;
  localparam int PUSH_W    = $clog2(PUSH_MAX + 1);
  localparam int PUSH_BITS = PUSH_MAX * 8;

  typedef enum logic [1:0] {
    KIND_SEQ = 2'd0,
    KIND_DIR = 2'd1,
    KIND_IND = 2'd2,
    KIND_RSV = 2'd3
  } kind_e;

  localparam logic [7:0] ST_IDLE = 8'h00;
  localparam logic [7:0] ST_SEQ  = 8'h01;
  localparam logic [7:0] ST_DIR  = 8'h02;
  localparam logic [7:0] ST_IND  = 8'h03;
  localparam logic [7:0] ST_OVF  = 8'h04;
endpackage

// File: rtl/trace_byte_fifo.sv
`timescale 1ns/1ps
module trace_byte_fifo
  import trace_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PUSH_W-1:0]             push_cnt,
  input  logic [PUSH_BITS-1:0]          push_data,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          out_valid,
  output logic [7:0]                    out_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop;

  assign pop = (count != '0);

  // multi-byte write: byte 0 of push_data sits in the top bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_MAX; i++) begin
      if (PUSH_W'(i) < push_cnt)
        mem[wr_ptr + PTR_W'(i)] <= push_data[(PUSH_MAX-1-i)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      wr_ptr    <= wr_ptr + PTR_W'(push_cnt);
      count     <= count + CNT_W'(push_cnt) - CNT_W'(pop);
      out_valid <= pop;
      if (pop) begin
        out_data <= mem[rd_ptr];
        rd_ptr   <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_event_encoder.sv
`timescale 1ns/1ps
module trace_event_encoder
  import trace_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trace_en,
  input  logic                 retire_valid,
  input  logic [ADDR_W-1:0]    retire_addr,
  input  logic [1:0]           retire_kind,
  input  logic [ADDR_W-1:0]    retire_target,
  input  logic [CNT_W-1:0]     fifo_free,
  output logic [7:0]           status_beat,
  output logic [PUSH_W-1:0]    push_cnt,
  output logic [PUSH_BITS-1:0] push_data,
  output logic                 need_sync
);
  localparam logic [CNT_W-1:0] ROOM_ONE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] ROOM_TWO = CNT_W'(PUSH_MAX);
  localparam logic [PUSH_W-1:0] CNT_ONE = PUSH_W'(ADDR_BYTES);
  localparam logic [PUSH_W-1:0] CNT_TWO = PUSH_W'(PUSH_MAX);

  kind_e      kind;
  logic [7:0] status_d;
  logic       sync_d;

  always_comb begin
    kind      = kind_e'(retire_kind);
    status_d  = ST_IDLE;
    push_cnt  = '0;
    push_data = '0;
    sync_d    = need_sync;
    if (!trace_en) begin
      sync_d = 1'b1;
    end else if (retire_valid) begin
      if (need_sync) begin
        if (kind == KIND_IND) begin
          if (fifo_free >= ROOM_TWO) begin
            status_d  = ST_IND;
            push_cnt  = CNT_TWO;
            push_data = {retire_addr, retire_target};
            sync_d    = 1'b0;
          end else begin
            status_d = ST_OVF;
          end
        end else if (fifo_free >= ROOM_ONE) begin
          status_d  = (kind == KIND_DIR) ? ST_DIR : ST_SEQ;
          push_cnt  = CNT_ONE;
          push_data = {retire_addr, {ADDR_W{1'b0}}};
          sync_d    = 1'b0;
        end else begin
          status_d = ST_OVF;
        end
      end else begin
        case (kind)
          KIND_DIR: status_d = ST_DIR;
          KIND_IND: begin
            if (fifo_free >= ROOM_ONE) begin
              status_d  = ST_IND;
              push_cnt  = CNT_ONE;
              push_data = {retire_target, {ADDR_W{1'b0}}};
            end else begin
              status_d = ST_OVF;
              sync_d   = 1'b1;
            end
          end
          default:  status_d = ST_SEQ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_beat <= ST_IDLE;
      need_sync   <= 1'b1;
    end else begin
      status_beat <= status_d;
      need_sync   <= sync_d;
    end
  end
endmodule

// File: rtl/trace_flow_encoder.sv
`timescale 1ns/1ps
module trace_flow_encoder
  import trace_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trace_en,
  input  logic              retire_valid,
  input  logic [31:0]       retire_addr,
  input  logic [1:0]        retire_kind,
  input  logic [31:0]       retire_target,
  output logic [7:0]        status_beat,
  output logic [7:0]        addr_beat,
  output logic              addr_valid
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0]     fifo_count;
  logic [CNT_W-1:0]     fifo_free;
  logic [PUSH_W-1:0]    push_cnt;
  logic [PUSH_BITS-1:0] push_data;
  logic                 need_sync;

  assign fifo_free = CNT_W'(DEPTH) - fifo_count;

  trace_event_encoder #(.CNT_W(CNT_W)) enc_i (
    .clk           (clk),
    .rst           (rst),
    .trace_en      (trace_en),
    .retire_valid  (retire_valid),
    .retire_addr   (retire_addr),
    .retire_kind   (retire_kind),
    .retire_target (retire_target),
    .fifo_free     (fifo_free),
    .status_beat   (status_beat),
    .push_cnt      (push_cnt),
    .push_data     (push_data),
    .need_sync     (need_sync)
  );

  trace_byte_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .push_cnt  (push_cnt),
    .push_data (push_data),
    .count     (fifo_count),
    .out_valid (addr_valid),
    .out_data  (addr_beat)
  );
endmodule

// File: rtl/trace_flow_encoder_chk.sv
`timescale 1ns/1ps
module trace_flow_encoder_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       trace_en,
  input logic                       retire_valid,
  input logic [1:0]                 retire_kind,
  input logic [7:0]                 status_beat,
  input logic                       addr_valid,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       need_sync
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status_beat == 8'h00 && !addr_valid));

  // R6
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !trace_en |=> (status_beat == 8'h00 && need_sync));

  // R3
  seq_no_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    (trace_en && retire_valid && !need_sync && (retire_kind == 2'd0 || retire_kind == 2'd3))
      |=> (status_beat == 8'h01 && fifo_count <= $past(fifo_count)));

  // R4
  direct_code_chk: assert property (@(posedge clk) disable iff (rst)
    (trace_en && retire_valid && !need_sync && retire_kind == 2'd1) |=> status_beat == 8'h02);

  // R8
  overflow_resync_chk: assert property (@(posedge clk) disable iff (rst)
    (status_beat == 8'h04) |-> need_sync);

  // R7
  status_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (status_beat != 8'h00) |-> $past(trace_en && retire_valid));

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  // R10
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fifo_count) == '0 && !$past(rst)) |-> !addr_valid);
endmodule

bind trace_flow_encoder trace_flow_encoder_chk #(.DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .trace_en     (trace_en),
  .retire_valid (retire_valid),
  .retire_kind  (retire_kind),
  .status_beat  (status_beat),
  .addr_valid   (addr_valid),
  .fifo_count   (fifo_count),
  .need_sync    (need_sync)
);

// File: tb/trace_flow_encoder_tb_top.sv
`timescale 1ns/1ps
module trace_flow_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trace_en = 1'b0;
  logic        retire_valid = 1'b0;
  logic [31:0] retire_addr = '0;
  logic [1:0]  retire_kind = '0;
  logic [31:0] retire_target = '0;
  logic [7:0]  status_beat;
  logic [7:0]  addr_beat;
  logic        addr_valid;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  trace_flow_encoder dut_i (
    .clk(clk), .rst(rst), .trace_en(trace_en), .retire_valid(retire_valid),
    .retire_addr(retire_addr), .retire_kind(retire_kind), .retire_target(retire_target),
    .status_beat(status_beat), .addr_beat(addr_beat), .addr_valid(addr_valid)
  );

  always @(negedge clk) if (!rst && addr_valid) got_q.push_back(addr_beat);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of input, then sample after the edge
  task automatic step(input logic v, input logic [31:0] a, input logic [1:0] k, input logic [31:0] t);
    retire_valid = v; retire_addr = a; retire_kind = k; retire_target = t;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic expect_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) exp_q.push_back(w[i*8 +: 8]);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 24; i++) step(1'b0, '0, 2'd0, '0);
    check({req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check({req, " byte"}, {24'h0, got_q[i]}, {24'h0, exp_q[i]});
    got_q.delete(); exp_q.delete();
  endtask

  task automatic t_reset_state();
    check("R1 status after reset", {24'h0, status_beat}, 32'h00);
    check("R1 addr_valid after reset", {31'h0, addr_valid}, 32'h0);
  endtask

  task automatic t_start_sync();
    step(1'b1, 32'h1000_0040, 2'd0, '0);
    check("R2 start status", {24'h0, status_beat}, 32'h01);
    check("R7 nothing yet", {31'h0, addr_valid}, 32'h0);
    @(negedge clk);
    check("R7 first byte timing", {23'h0, addr_valid, addr_beat}, {23'h0, 1'b1, 8'h10});
    expect_word(32'h1000_0040);
    drain("R2");
  endtask

  task automatic t_seq_dir_idle();
    step(1'b1, 32'h1000_0044, 2'd0, '0);
    check("R3 sequential", {24'h0, status_beat}, 32'h01);
    step(1'b1, 32'h1000_0048, 2'd3, 32'hdead_beef);
    check("R3 reserved kind", {24'h0, status_beat}, 32'h01);
    step(1'b1, 32'h1000_004c, 2'd1, 32'h1234_5678);
    check("R4 direct", {24'h0, status_beat}, 32'h02);
    step(1'b0, 32'h1000_0050, 2'd1, '0);
    check("R6 idle", {24'h0, status_beat}, 32'h00);
    drain("R3 R4 no bytes");
  endtask

  task automatic t_indirect();
    step(1'b1, 32'h2000_0000, 2'd2, 32'hcafe_f00d);
    check("R5 indirect", {24'h0, status_beat}, 32'h03);
    expect_word(32'hcafe_f00d);
    step(1'b1, 32'hcafe_f00d, 2'd2, 32'h0bad_c0de);
    check("R5 indirect back-to-back", {24'h0, status_beat}, 32'h03);
    expect_word(32'h0bad_c0de);
    drain("R5");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 32'h3000_0000 + i, 2'd2, 32'h4000_0000 + 32'(i * 16));
      check("R8 fill", {24'h0, status_beat}, 32'h03);
      expect_word(32'h4000_0000 + 32'(i * 16));
    end
    step(1'b1, 32'h3000_0010, 2'd2, 32'h5555_aaaa);
    check("R8 overflow status", {24'h0, status_beat}, 32'h04);
    step(1'b1, 32'h6000_0100, 2'd1, '0);
    check("R8 resync status", {24'h0, status_beat}, 32'h02);
    expect_word(32'h6000_0100);
    drain("R8 R10");
  endtask

  task automatic t_disable_resync();
    trace_en = 1'b0;
    step(1'b1, 32'h7000_0000, 2'd2, 32'h7777_0000);
    check("R6 disabled", {24'h0, status_beat}, 32'h00);
    trace_en = 1'b1;
    step(1'b1, 32'h7000_0010, 2'd2, 32'h8888_1234);
    check("R9 sync on indirect", {24'h0, status_beat}, 32'h03);
    expect_word(32'h7000_0010);
    expect_word(32'h8888_1234);
    drain("R9");
  endtask

  task automatic t_reset_mid();
    step(1'b1, 32'h9000_0000, 2'd2, 32'h9999_9999);
    step(1'b1, 32'h9999_9999, 2'd2, 32'habab_abab);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset mid status", {24'h0, status_beat}, 32'h00);
    check("R1 reset mid valid", {31'h0, addr_valid}, 32'h0);
    got_q.delete();
    rst = 1'b0;
    drain("R1 no stale bytes");
    step(1'b1, 32'ha000_0000, 2'd0, '0);
    check("R1 resync status", {24'h0, status_beat}, 32'h01);
    expect_word(32'ha000_0000);
    drain("R1 resync");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    trace_en = 1'b1;
    t_start_sync();
    t_seq_dir_idle();
    t_indirect();
    t_overflow();
    t_disable_resync();
    t_reset_mid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule